// File: doc/BRIEF.md
# Video Control Signal Glitch Filter

This block cleans up the three video timing controls (horizontal sync, vertical sync and data enable) in the pixel clock domain, just before they are packed into an outgoing serial frame. With filtering switched on, a control level is accepted only once it has been seen at a minimum number of consecutive active clock edges, so short pulses never reach the output. With filtering switched off, every level is forwarded whatever its width. Both paths share one fixed latency, so the three outputs stay aligned with each other and with pixel data that is delayed by the same amount.

Each forwarded signal also runs through a rate monitor. Horizontal sync and data enable may change at most twice in any span of 130 pixel clocks; vertical sync may change only once in such a span. A change that arrives too early sets a sticky flag for that signal, which holds until it is cleared through a dedicated input. A build parameter selects whether the rising or the falling pixel clock edge is the active one.

Top module: `ctl_sig_filter`

## Requirements
- R1: While `rst_n` is low, the three outputs and all three bits of `viol` are 0.
- R2: With `filt_en` high, an input level present at fewer than MIN_PULSE (default 3) consecutive active edges never appears on the corresponding output.
- R3: With `filt_en` high, a level present at MIN_PULSE or more consecutive active edges appears on the output right after the MIN_PULSE-th of those edges (2 clocks after the first edge that samples it, for the default) and stays until a new level is accepted.
- R4: With `filt_en` low, every sampled level appears on the output, with no minimum width, MIN_PULSE-1 clocks after the edge that samples it — the same delay as the filtered path.
- R5: The three channels have identical latency: inputs that change together produce output edges in the same clock.
- R6: `viol[0]` (horizontal sync) and `viol[2]` (data enable) set when that output changes less than WINDOW (default 130) clocks after the change two before it; a gap of exactly WINDOW clocks is legal.
- R7: `viol[1]` (vertical sync) sets when that output changes less than WINDOW clocks after its previous change; a gap of exactly WINDOW is legal.
- R8: A set `viol` bit stays set until `clr_viol` is high at an active edge; a new violation at the same edge as a clear leaves the bit set.
- R9: Toggling `filt_en` while the inputs are steady creates no output edge; a new `filt_en` value takes effect at the next active edge.
- R10: With SAMPLE_ON_FALL set to 1, all state updates on the falling edge of `pix_clk`, with the same behaviour as above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| filt_en | input | 1 | 1 = suppress short pulses, 0 = forward all levels |
| clr_viol | input | 1 | Clears all violation flags at the active edge |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| de_in | input | 1 | Raw data enable |
| hs_out | output | 1 | Conditioned horizontal sync |
| vs_out | output | 1 | Conditioned vertical sync |
| de_out | output | 1 | Conditioned data enable |
| viol | output | 3 | Sticky rate flags: bit 0 hs, bit 1 vs, bit 2 de |

## Verification
The bench builds two copies with the default widths (MIN_PULSE 3, WINDOW 130, allowances 2/1/2): one active on the rising edge and one with SAMPLE_ON_FALL set, which is checked half a clock earlier than the other so that a wrong edge shows up. These defaults place the 1- and 2-clock glitch cases, the 129 versus 130 clock spacing boundaries for both allowance values, and the set-and-clear race within a few thousand cycles.

// File: rtl/ctlf_pkg.sv
package ctlf_pkg;

   typedef enum int unsigned {
      CH_HS = 0,
      CH_VS = 1,
      CH_DE = 2
   } ctl_ch_e;

   localparam int unsigned NUM_CH = 3;

   // Transition allowance of a channel within one window.
   function automatic int unsigned chan_allow(input int unsigned ch,
                                              input int unsigned hs_max,
                                              input int unsigned vs_max,
                                              input int unsigned de_max);
      int unsigned r;
      case (ch)
         CH_HS:   r = hs_max;
         CH_VS:   r = vs_max;
         default: r = de_max;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ctlf_pulse_filt.sv
module ctlf_pulse_filt #(
   parameter int unsigned MIN_PULSE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic dout,
   output logic dout_edge
);

   localparam int unsigned DEPTH = MIN_PULSE - 1;

   // hist_q[0] holds the newest past sample, hist_q[DEPTH-1] the oldest
   logic [DEPTH-1:0] hist_q;
   logic             dout_q;
   logic             dout_nxt;
   logic             stable;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q <= '0;
            else        hist_q <= din;
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q <= '0;
            else        hist_q <= {hist_q[DEPTH-2:0], din};
         end
      end
   endgenerate

   // current sample plus DEPTH past samples all agree
   assign stable = (hist_q == {DEPTH{din}});

   always_comb begin
      if (en) dout_nxt = stable ? din : dout_q;
      else    dout_nxt = hist_q[DEPTH-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= 1'b0;
      else        dout_q <= dout_nxt;
   end

   assign dout      = dout_q;
   assign dout_edge = dout_nxt ^ dout_q;

endmodule

// File: rtl/ctlf_rate_mon.sv
module ctlf_rate_mon #(
   parameter int unsigned WINDOW  = 130,
   parameter int unsigned MAX_TOG = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tog,
   input  logic clr,
   output logic flag
);

   localparam int unsigned   AW  = $clog2(WINDOW + 1);
   localparam logic [AW-1:0] WIN = AW'(WINDOW);

   // age_q[k]: clocks since the (k+1)-th most recent transition, saturating
   logic [AW-1:0] age_q [MAX_TOG];
   logic          too_soon;
   logic          flag_q;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
      return (a >= WIN) ? WIN : a + AW'(1);
   endfunction

   assign too_soon = tog && (age_q[MAX_TOG-1] < WIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < MAX_TOG; k++) age_q[k] <= WIN;
      end else if (tog) begin
         age_q[0] <= AW'(1);
         for (int k = 1; k < MAX_TOG; k++) age_q[k] <= bump(age_q[k-1]);
      end else begin
         for (int k = 0; k < MAX_TOG; k++) age_q[k] <= bump(age_q[k]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= too_soon | (flag_q & ~clr);
   end

   assign flag = flag_q;

endmodule

// File: rtl/ctl_sig_filter.sv
module ctl_sig_filter
   import ctlf_pkg::*;
#(
   parameter int unsigned MIN_PULSE      = 3,
   parameter int unsigned WINDOW         = 130,
   parameter int unsigned HS_MAX_TOG     = 2,
   parameter int unsigned VS_MAX_TOG     = 1,
   parameter int unsigned DE_MAX_TOG     = 2,
   parameter bit          SAMPLE_ON_FALL = 1'b0
) (
   input  logic       pix_clk,
   input  logic       rst_n,
   input  logic       filt_en,
   input  logic       clr_viol,
   input  logic       hs_in,
   input  logic       vs_in,
   input  logic       de_in,
   output logic       hs_out,
   output logic       vs_out,
   output logic       de_out,
   output logic [2:0] viol
);

   // elaboration-time parameter checks
   generate
      if (MIN_PULSE < 2) begin : g_bad_pulse
         $error("MIN_PULSE must be at least 2");
      end
      if (WINDOW < 2) begin : g_bad_window
         $error("WINDOW must be at least 2");
      end
      if (HS_MAX_TOG < 1 || VS_MAX_TOG < 1 || DE_MAX_TOG < 1) begin : g_bad_allow
         $error("every transition allowance must be at least 1");
      end
   endgenerate

   logic core_clk;

   generate
      if (SAMPLE_ON_FALL) begin : g_fall
         assign core_clk = ~pix_clk;
      end else begin : g_rise
         assign core_clk = pix_clk;
      end
   endgenerate

   logic [NUM_CH-1:0] raw;
   logic [NUM_CH-1:0] filt;
   logic [NUM_CH-1:0] edg;
   logic [NUM_CH-1:0] flag;

   assign raw = {de_in, vs_in, hs_in};

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam int unsigned ALLOW =
            chan_allow(c, HS_MAX_TOG, VS_MAX_TOG, DE_MAX_TOG);

         ctlf_pulse_filt #(
            .MIN_PULSE (MIN_PULSE)
         ) u_filt (
            .clk       (core_clk),
            .rst_n     (rst_n),
            .en        (filt_en),
            .din       (raw[c]),
            .dout      (filt[c]),
            .dout_edge (edg[c])
         );

         ctlf_rate_mon #(
            .WINDOW  (WINDOW),
            .MAX_TOG (ALLOW)
         ) u_rate (
            .clk   (core_clk),
            .rst_n (rst_n),
            .tog   (edg[c]),
            .clr   (clr_viol),
            .flag  (flag[c])
         );
      end
   endgenerate

   assign hs_out = filt[CH_HS];
   assign vs_out = filt[CH_VS];
   assign de_out = filt[CH_DE];
   assign viol   = flag;

endmodule

// File: rtl/ctlf_checker.sv
module ctlf_checker #(
   parameter int unsigned MIN_PULSE = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       filt_en,
   input logic       clr_viol,
   input logic [2:0] raw,
   input logic [2:0] sig_out,
   input logic [2:0] viol
);

   localparam int unsigned   RW   = $clog2(MIN_PULSE + 1);
   localparam logic [RW-1:0] RMAX = RW'(MIN_PULSE);

   logic [2:0]         last_q;
   logic [2:0][RW-1:0] run_q;
   logic [2:0][RW-1:0] run_now;

   always_comb begin
      for (int c = 0; c < 3; c++) begin
         if (raw[c] == last_q[c])
            run_now[c] = (run_q[c] >= RMAX) ? RMAX : run_q[c] + RW'(1);
         else
            run_now[c] = RW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '0;
         run_q  <= '0;
      end else begin
         last_q <= raw;
         run_q  <= run_now;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (sig_out == 3'b000 && viol == 3'b000));

   generate
      for (genvar c = 0; c < 3; c++) begin : g_a
         assert_min_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(filt_en) && sig_out[c] != $past(sig_out[c]))
               |-> ($past(run_now[c]) >= RMAX));

         assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(viol[c]) |-> $past(clr_viol));
      end
   endgenerate

   assert_hs_flag_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol[0]) |-> (sig_out[0] != $past(sig_out[0])));

   assert_vs_flag_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol[1]) |-> (sig_out[1] != $past(sig_out[1])));

   assert_de_flag_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol[2]) |-> (sig_out[2] != $past(sig_out[2])));

endmodule

bind ctl_sig_filter ctlf_checker #(
   .MIN_PULSE (MIN_PULSE)
) u_chk (
   .clk      (core_clk),
   .rst_n    (rst_n),
   .filt_en  (filt_en),
   .clr_viol (clr_viol),
   .raw      ({de_in, vs_in, hs_in}),
   .sig_out  ({de_out, vs_out, hs_out}),
   .viol     (viol)
);

// File: tb/tb_ctl_sig_filter.sv
module tb_ctl_sig_filter;

   localparam int CLK_PERIOD = 10;
   localparam int P          = 3;
   localparam int W          = 130;
   localparam int LIMIT      = 200000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       filt_en;
   logic       clr_viol;
   logic       hs_in, vs_in, de_in;
   logic       hs_r, vs_r, de_r;
   logic [2:0] viol_r;
   logic       hs_f, vs_f, de_f;
   logic [2:0] viol_f;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ctl_sig_filter dut (
      .pix_clk (clk), .rst_n (rst_n), .filt_en (filt_en), .clr_viol (clr_viol),
      .hs_in (hs_in), .vs_in (vs_in), .de_in (de_in),
      .hs_out (hs_r), .vs_out (vs_r), .de_out (de_r), .viol (viol_r)
   );

   ctl_sig_filter #(.SAMPLE_ON_FALL (1'b1)) dut_fall (
      .pix_clk (clk), .rst_n (rst_n), .filt_en (filt_en), .clr_viol (clr_viol),
      .hs_in (hs_in), .vs_in (vs_in), .de_in (de_in),
      .hs_out (hs_f), .vs_out (vs_f), .de_out (de_f), .viol (viol_f)
   );

   // ---------------- behavioural reference ----------------
   logic [2:0] hist[$];
   logic [2:0] exp_out;
   logic [2:0] exp_viol;
   int         tt [3][4];
   int         ecount;
   int         lim [3] = '{2, 1, 2};

   function automatic void model_reset();
      hist.delete();
      for (int k = 0; k < P - 1; k++) hist.push_back(3'b000);
      exp_out  = 3'b000;
      exp_viol = 3'b000;
      ecount   = 0;
      for (int s = 0; s < 3; s++)
         for (int k = 0; k < 4; k++) tt[s][k] = -1000000;
   endfunction

   function automatic void model_edge(input logic [2:0] x, input logic en, input logic clr);
      logic [2:0] nxt;
      hist.push_front(x);
      while (hist.size() > P) void'(hist.pop_back());
      for (int s = 0; s < 3; s++) begin
         logic newv;
         if (en) begin
            logic eq;
            eq = 1'b1;
            for (int k = 0; k < P; k++) if (hist[k][s] != x[s]) eq = 1'b0;
            nxt[s] = eq ? x[s] : exp_out[s];
         end else begin
            nxt[s] = hist[P-1][s];
         end
         newv = 1'b0;
         if (nxt[s] != exp_out[s]) begin
            int cnt;
            cnt = 1;
            for (int k = 0; k < 4; k++) if (ecount - tt[s][k] < W) cnt++;
            if (cnt > lim[s]) newv = 1'b1;
            for (int k = 3; k > 0; k--) tt[s][k] = tt[s][k-1];
            tt[s][0] = ecount;
         end
         exp_viol[s] = newv | (exp_viol[s] & ~clr);
      end
      exp_out = nxt;
      ecount++;
   endfunction

   task automatic compare(input string tag, input string which,
                          input logic [2:0] o, input logic [2:0] v);
      n_tests++;
      if ({o, v} !== {exp_out, exp_viol}) begin
         n_fail++;
         $display("FAIL %s %s cycle %0d: out(de,vs,hs)=%b viol=%b expected out=%b viol=%b",
                  tag, which, ecount, o, v, exp_out, exp_viol);
      end
   endtask

   // one active edge: inputs set away from edges, falling copy checked first
   task automatic step(input logic [2:0] x, input logic en, input logic clr, input string tag);
      {de_in, vs_in, hs_in} = x;
      filt_en  = en;
      clr_viol = clr;
      @(negedge clk); #1;
      model_edge(x, en, clr);
      compare("R10", "falling-edge copy", {de_f, vs_f, hs_f}, viol_f);
      @(posedge clk); #1;
      compare(tag, "rising-edge copy", {de_r, vs_r, hs_r}, viol_r);
   endtask

   task automatic hold(input logic [2:0] x, input logic en, input logic clr,
                       input int n, input string tag);
      for (int i = 0; i < n; i++) step(x, en, clr, tag);
   endtask

   // ---------------- watchdog ----------------
   bit done = 1'b0;
   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      rst_n    = 1'b0;
      filt_en  = 1'b1;
      clr_viol = 1'b0;
      {de_in, vs_in, hs_in} = 3'b111;
      model_reset();
      repeat (4) @(posedge clk);
      #1;
      // R1: outputs and flags low while reset is held, despite high inputs
      compare("R1", "rising-edge copy", {de_r, vs_r, hs_r}, viol_r);
      compare("R1", "falling-edge copy", {de_f, vs_f, hs_f}, viol_f);
      {de_in, vs_in, hs_in} = 3'b000;
      rst_n = 1'b1;
      model_reset();

      hold(3'b000, 1, 0, 6, "R3");
      // R2: 1- and 2-clock pulses on hs and de are removed
      hold(3'b001, 1, 0, 1, "R2");
      hold(3'b000, 1, 0, 10, "R2");
      hold(3'b001, 1, 0, 2, "R2");
      hold(3'b000, 1, 0, 10, "R2");
      hold(3'b100, 1, 0, 1, "R2");
      hold(3'b000, 1, 0, 10, "R2");
      hold(3'b100, 1, 0, 2, "R2");
      hold(3'b000, 1, 0, 10, "R2");
      // R3: a 3-clock pulse passes with fixed latency
      hold(3'b001, 1, 0, 3, "R3");
      hold(3'b000, 1, 0, 140, "R3");
      // R5: all three change together and stay aligned
      hold(3'b111, 1, 0, 200, "R5");
      hold(3'b000, 1, 0, 200, "R5");
      // R4: filter off, single-clock pulses pass
      hold(3'b001, 0, 0, 1, "R4");
      hold(3'b000, 0, 0, 200, "R4");
      hold(3'b100, 0, 0, 1, "R4");
      hold(3'b000, 0, 0, 200, "R4");
      // R9: enable toggled under steady inputs, low and high levels
      hold(3'b000, 1, 0, 5, "R9");
      hold(3'b000, 0, 0, 5, "R9");
      hold(3'b000, 1, 0, 5, "R9");
      hold(3'b101, 1, 0, 10, "R9");
      hold(3'b101, 0, 0, 5, "R9");
      hold(3'b101, 1, 0, 5, "R9");
      hold(3'b101, 0, 0, 3, "R9");
      hold(3'b000, 1, 0, 200, "R9");
      // R6: third hs change well inside the window
      hold(3'b001, 1, 0, 5, "R6");
      hold(3'b000, 1, 0, 5, "R6");
      hold(3'b001, 1, 0, 200, "R6");
      // R8: flag still set after long idle, then cleared
      hold(3'b001, 1, 1, 1, "R8");
      hold(3'b001, 1, 0, 20, "R8");
      hold(3'b000, 1, 0, 200, "R8");
      // R6: de changes spaced 65/65 (gap of 130 legal), then 65/64 (violation)
      hold(3'b100, 1, 0, 65, "R6");
      hold(3'b000, 1, 0, 65, "R6");
      hold(3'b100, 1, 0, 200, "R6");
      hold(3'b000, 1, 0, 65, "R6");
      hold(3'b100, 1, 0, 64, "R6");
      hold(3'b000, 1, 0, 200, "R6");
      hold(3'b000, 1, 1, 1, "R8");
      // R7: vs pulse of 129 clocks violates, 130 does not
      hold(3'b010, 1, 0, 129, "R7");
      hold(3'b000, 1, 0, 200, "R7");
      hold(3'b000, 1, 1, 1, "R8");
      hold(3'b010, 1, 0, 130, "R7");
      hold(3'b000, 1, 0, 200, "R7");
      // R8: violation while clear is held high: set wins, then clears
      hold(3'b001, 1, 1, 4, "R8");
      hold(3'b000, 1, 1, 4, "R8");
      hold(3'b001, 1, 1, 4, "R8");
      hold(3'b001, 1, 1, 10, "R8");
      hold(3'b000, 1, 0, 200, "R8");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule